// File: doc/BRIEF.md
# Late-Write Burst Synchronous RAM

This block is a single-port synchronous RAM whose data bus is shared between reads and writes, so that reads and writes can follow each other on consecutive clock edges with no idle cycle. Address and control inputs are registered on the rising edge. Read data leaves the array without a further register, so a read word is visible during the cycle that follows the edge at which its address was taken. Write data arrives one edge after its address. Because of this, a read command can be followed directly by a write command with no bus turnaround, and the block turns its own output drivers off during every write data phase.

A word is made of four 9-bit byte lanes, and each lane has its own active-low write enable. A two-bit burst sequencer can step the low address bits after a load, either in linear order or in interleaved order. A clock enable stalls the whole pipeline. Three chip enables select the device. An asynchronous output enable gates the drivers. A sleep input parks the block with its contents kept. The tri-state bus is modelled as three signals: data in, data out and a drive flag.

Top module: `lw_sram`

## Requirements
- R1: A command is accepted only at an edge with `clk_en_n` low and `adv_ld` low. It selects the device only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other enable combination makes the cycle a deselect, and `dq_oe` is 0 in the cycle after that edge.
- R2: After a read is accepted at edge k, `dq_out` carries the word at the registered address during the cycle after edge k, and `dq_oe` is 1 while `oe_n` is 0.
- R3: `oe_n` acts without a clock. During a read phase, `dq_oe` falls as soon as `oe_n` goes high and rises again as soon as it goes low.
- R4: A write registers its address and lane enables at edge k. The value on `dq_in` at the next enabled edge k+1 is stored. A new command is accepted at that same edge k+1.
- R5: Lane i covers `dq_in[9i+8:9i]`. The lane is written only if `bw_n[i]` is 0, and every other lane keeps its contents. With `bw_n`=4'hF a write changes nothing.
- R6: `dq_oe` is 0 during the data phase of every write, whatever the level of `oe_n`.
- R7: An enabled edge with `adv_ld`=1 during an active access moves to the next burst beat. The chip enables and `we_n` are ignored at that edge, and the access type and the upper address bits are kept. The low two address bits of beat n, counted from start s, are (s+n) mod 4 when `burst_mode`=0 and s XOR n when `burst_mode`=1. The sequence wraps after four beats.
- R8: In a burst write, `bw_n` is sampled again at every beat, and each beat uses its own lane enables.
- R9: An edge with `clk_en_n` high is ignored. Nothing is written, the command state holds, and any read output stays on the bus. A pending write takes its data at the next enabled edge.
- R10: After reset the block is deselected and `dq_oe` is 0, even with `oe_n` low.
- R11: Two edges after `sleep` rises, `dq_oe` is 0, commands are ignored, any pending access is dropped, and the array is kept. Two edges after `sleep` falls, commands are accepted again.
- R12: A read of an address, issued at the edge that completes a write to that same address, returns the newly written data.
- R13: An edge with `adv_ld`=1 while the block is deselected leaves it deselected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the block |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the burst |
| we_n | input | 1 | 0 = write, 1 = read (sampled on load) |
| bw_n | input | LANES | Active-low per-lane write enables |
| addr | input | ADDR_W | Word address |
| burst_mode | input | 1 | 0 = linear, 1 = interleaved beat order |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous sleep request |
| dq_in | input | LANES*LANE_W | Bus value seen by the RAM (write data) |
| dq_out | output | LANES*LANE_W | Array word at the current access address |
| dq_oe | output | 1 | RAM drives the bus when 1 |

## Verification
Every address is first written back-to-back, each command paired with the data of the write before it, and then read back-to-back. This separates a correct late-write alignment from data captured one word early or late. All sixteen lane-enable masks are applied at one address, each followed at once by a read of that address. This tells lane isolation apart from whole-word writes, and also checks read-after-write on the completing edge. Bursts are run from all four start offsets in both orders, with a fifth beat to show the wrap, and a burst write changes its mask on every beat. Stalls placed inside reads and inside write data phases, the seven partial chip-select combinations, and a sleep cycle carrying ignored commands show which inputs have no effect and when.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int BURST_BITS = 2;

    typedef logic [BURST_BITS-1:0] beat_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Decoded view of the command inputs at one edge
    typedef struct packed {
        logic take;   // edge is enabled and the block is awake
        logic load;   // new command (adv_ld low)
        logic hit;    // all chip enables active
        logic write;  // we_n low
    } cmd_t;

    // Low address bits of beat n in a burst that started at offset start
    function automatic beat_t seq_offset(input beat_t start, input beat_t n,
                                         input logic interleave);
        return interleave ? (start ^ n) : beat_t'(start + n);
    endfunction

endpackage

// File: rtl/lw_sram_burst.sv
module lw_sram_burst
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  beat_t             beat,
    input  logic              interleave,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int HI_W = ADDR_W - BURST_BITS;

    logic [HI_W-1:0] hi_part;
    beat_t           lo_start;

    assign hi_part  = base[ADDR_W-1:BURST_BITS];
    assign lo_start = base[BURST_BITS-1:0];
    assign cur_addr = {hi_part, seq_offset(lo_start, beat, interleave)};

endmodule

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dozing,
    input  cmd_t              cmd,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_mode,
    output op_e               op,
    output logic [ADDR_W-1:0] base,
    output beat_t             beat,
    output logic              interleave,
    output logic [LANES-1:0]  lane_mask
);
    op_e               op_q;
    logic [ADDR_W-1:0] base_q;
    beat_t             beat_q;
    logic              mode_q;
    logic [LANES-1:0]  mask_q;

    always_ff @(posedge clk) begin
        if (rst || dozing) begin
            op_q   <= OP_IDLE;
            beat_q <= '0;
        end else if (cmd.take) begin
            if (cmd.load) begin
                if (cmd.hit) begin
                    op_q   <= cmd.write ? OP_WRITE : OP_READ;
                    base_q <= addr;
                    beat_q <= '0;
                    mode_q <= burst_mode;
                    mask_q <= ~bw_n;
                end else begin
                    op_q <= OP_IDLE;
                end
            end else if (op_q != OP_IDLE) begin
                beat_q <= beat_q + beat_t'(1);
                mask_q <= ~bw_n;
            end
        end
    end

    assign op         = op_q;
    assign base       = base_q;
    assign beat       = beat_q;
    assign interleave = mode_q;
    assign lane_mask  = mask_q;

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g])
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clk_en_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    burst_mode,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    localparam int ZZ_STAGES = 2;

    logic [ZZ_STAGES-1:0] zz_q;
    logic                 dozing;
    logic                 chip_sel;
    cmd_t                 cmd;
    op_e                  cur_op;
    logic [ADDR_W-1:0]    base;
    beat_t                beat;
    logic                 interleave;
    logic [LANES-1:0]     lane_mask;
    logic [ADDR_W-1:0]    acc_addr;
    logic                 wr_en;

    // Sleep request passes two flops before it takes effect
    always_ff @(posedge clk) begin
        if (rst) zz_q <= '0;
        else     zz_q <= {zz_q[ZZ_STAGES-2:0], sleep};
    end
    assign dozing = zz_q[ZZ_STAGES-1];

    assign chip_sel  = !ce1_n && ce2 && !ce3_n;
    assign cmd.take  = !clk_en_n && !dozing;
    assign cmd.load  = !adv_ld;
    assign cmd.hit   = chip_sel;
    assign cmd.write = !we_n;

    lw_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .dozing     (dozing),
        .cmd        (cmd),
        .bw_n       (bw_n),
        .addr       (addr),
        .burst_mode (burst_mode),
        .op         (cur_op),
        .base       (base),
        .beat       (beat),
        .interleave (interleave),
        .lane_mask  (lane_mask)
    );

    lw_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .base       (base),
        .beat       (beat),
        .interleave (interleave),
        .cur_addr   (acc_addr)
    );

    // Late write: data for the registered write is taken at the next enabled edge
    assign wr_en = cmd.take && (cur_op == OP_WRITE);

    lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (acc_addr),
        .wr_mask (lane_mask),
        .wr_data (dq_in),
        .rd_addr (acc_addr),
        .rd_data (dq_out)
    );

    assign dq_oe = (cur_op == OP_READ) && !oe_n && !dozing;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en_n,
    input logic              adv_ld,
    input logic              chip_sel,
    input logic              we_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic              dozing,
    input logic              wr_en,
    input op_e               cur_op,
    input logic [ADDR_W-1:0] acc_addr
);
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !dozing && !adv_ld && !chip_sel) |=> !dq_oe); // R1

    AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !oe_n); // R3

    AST_WRITE_PHASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !dozing && !adv_ld && chip_sel && !we_n) |=> !dq_oe); // R6

    AST_BURST_KEEPS_TYPE: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !dozing && adv_ld && cur_op != OP_IDLE) |=> $stable(cur_op)); // R7

    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |-> !wr_en); // R9

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (clk_en_n && !dozing) |=> ($stable(cur_op) && $stable(acc_addr))); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!dq_oe && cur_op == OP_IDLE)); // R10

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
        dozing |-> (!dq_oe && !wr_en)); // R11

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (adv_ld && cur_op == OP_IDLE) |=> cur_op == OP_IDLE); // R13

endmodule

bind lw_sram lw_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en_n (clk_en_n),
    .adv_ld   (adv_ld),
    .chip_sel (chip_sel),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dq_oe    (dq_oe),
    .dozing   (dozing),
    .wr_en    (wr_en),
    .cur_op   (cur_op),
    .acc_addr (acc_addr)
);

// File: tb/lw_sram_bench.sv
module lw_sram_bench;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int WW = NL * LW;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b0;
    logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic          adv_ld = 1'b0, we_n = 1'b1;
    logic [NL-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic          burst_mode = 1'b0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [WW-1:0] dq_in = '0;
    logic [WW-1:0] dq_out;
    logic          dq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [WW-1:0] model [NW];

    always #4 clk = ~clk;

    lw_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_lw_sram (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .addr(addr),
        .burst_mode(burst_mode), .oe_n(oe_n), .sleep(sleep), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [WW-1:0] pat(input int i);
        logic [LW-1:0] b;
        b = LW'(i * 37 + 11);
        return {b, ~b, LW'(b + 9'd100), LW'(b ^ 9'h155)};
    endfunction

    function automatic logic [WW-1:0] merge(input logic [WW-1:0] old_w,
                                            input logic [WW-1:0] new_w,
                                            input logic [NL-1:0] en);
        logic [WW-1:0] r;
        r = old_w;
        for (int l = 0; l < NL; l++)
            if (en[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
        return r;
    endfunction

    task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic sel_cmd(input logic adv, input logic wen, input logic [NL-1:0] bwn,
                           input logic [AW-1:0] a, input logic [WW-1:0] d);
        clk_en_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        adv_ld = adv; we_n = wen; bw_n = bwn; addr = a; dq_in = d;
    endtask

    task automatic desel(input logic [WW-1:0] d);
        clk_en_n = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
        adv_ld = 1'b0; we_n = 1'b1; bw_n = '1; dq_in = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R10: reset leaves the bus undriven even with oe_n low
        chk("R10 reset drive", WW'(dq_oe), '0);

        // R4 sweep: back-to-back writes, data one edge late
        for (int i = 0; i < NW; i++) begin
            sel_cmd(1'b0, 1'b0, '0, AW'(i), (i == 0) ? '0 : pat(i - 1));
            step();
            chk("R6 write phase drive", WW'(dq_oe), '0);
            model[i] = pat(i);
        end
        desel(pat(NW - 1));
        step();
        // R2 sweep: back-to-back reads
        for (int i = 0; i < NW; i++) begin
            sel_cmd(1'b0, 1'b1, '1, AW'(i), '0);
            step();
            chk("R2 read drive", WW'(dq_oe), 1);
            chk("R4 read data", dq_out, model[i]);
        end

        // R5/R12: all lane masks at one address, each read on the completing edge
        for (int m = 0; m < 16; m++) begin
            sel_cmd(1'b0, 1'b0, ~NL'(m), AW'(10), '0);
            step();
            chk("R6 write phase drive", WW'(dq_oe), '0);
            sel_cmd(1'b0, 1'b1, '1, AW'(10), pat(200 + m));
            model[10] = merge(model[10], pat(200 + m), NL'(m));
            step();
            chk("R12 read after write", dq_out, model[10]);
            chk("R5 lane drive", WW'(dq_oe), 1);
        end

        // R3: asynchronous output enable
        sel_cmd(1'b0, 1'b1, '1, AW'(5), '0);
        step();
        oe_n = 1'b1;
        #1;
        chk("R3 oe high", WW'(dq_oe), '0);
        oe_n = 1'b0;
        #1;
        chk("R3 oe low", WW'(dq_oe), 1);
        // R6: a write phase stays quiet with oe_n low
        sel_cmd(1'b0, 1'b0, '1, AW'(5), '0);
        step();
        chk("R6 no-byte write phase", WW'(dq_oe), '0);

        // R1: each non-selecting enable combination deselects
        for (int c = 0; c < 8; c++) begin
            if (c == 3'b010) continue;
            sel_cmd(1'b0, 1'b1, '1, AW'(1), '0);
            step();
            chk("R1 selected read", dq_out, model[1]);
            {ce1_n, ce2, ce3_n} = 3'(c);
            step();
            chk("R1 deselect drive", WW'(dq_oe), '0);
        end
        // R13: advance while deselected stays deselected
        sel_cmd(1'b1, 1'b1, '1, AW'(1), '0);
        step();
        chk("R13 continue deselect", WW'(dq_oe), '0);
        // R5: write with no lanes left address 5 unchanged
        sel_cmd(1'b0, 1'b1, '1, AW'(5), '0);
        step();
        chk("R5 no-lane write", dq_out, model[5]);

        // R7: burst reads, both orders, every start offset, plus wrap beat
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                sel_cmd(1'b0, 1'b1, '1, AW'(32 + s), '0);
                burst_mode = md[0];
                step();
                for (int n = 0; n < 5; n++) begin
                    int off;
                    off = md ? (s ^ (n % 4)) : ((s + n) % 4);
                    chk("R7 burst beat", dq_out, model[32 + off]);
                    chk("R7 burst drive", WW'(dq_oe), 1);
                    clk_en_n = 1'b0; adv_ld = 1'b1; ce1_n = 1'b1; we_n = 1'b0;
                    burst_mode = ~md[0];
                    step();
                end
            end
        end
        burst_mode = 1'b0;

        // R8: burst write with a new mask each beat
        begin
            logic [NL-1:0] msk [4];
            msk[0] = 4'hF; msk[1] = 4'h1; msk[2] = 4'h0; msk[3] = 4'h8;
            sel_cmd(1'b0, 1'b0, ~msk[0], AW'(40), '0);
            step();
            for (int n = 1; n < 5; n++) begin
                if (n < 4) sel_cmd(1'b1, 1'b1, ~msk[n], AW'(0), pat(300 + n - 1));
                else       desel(pat(300 + n - 1));
                model[40 + n - 1] = merge(model[40 + n - 1], pat(300 + n - 1), msk[n - 1]);
                step();
                chk("R8 burst write drive", WW'(dq_oe), '0);
            end
            for (int n = 0; n < 4; n++) begin
                sel_cmd(1'b0, 1'b1, '1, AW'(40 + n), '0);
                step();
                chk("R8 burst write data", dq_out, model[40 + n]);
            end
        end

        // R9: stall holds a read on the bus
        sel_cmd(1'b0, 1'b1, '1, AW'(7), '0);
        step();
        for (int k = 0; k < 3; k++) begin
            clk_en_n = 1'b1; addr = AW'(9); we_n = 1'b0; adv_ld = 1'b0;
            step();
            chk("R9 stall read data", dq_out, model[7]);
            chk("R9 stall read drive", WW'(dq_oe), 1);
        end
        // R9: stall inside a write data phase delays the data capture
        sel_cmd(1'b0, 1'b0, '0, AW'(8), '0);
        step();
        sel_cmd(1'b0, 1'b1, '1, AW'(8), pat(401));
        clk_en_n = 1'b1;
        step();
        chk("R9 stalled write drive", WW'(dq_oe), '0);
        sel_cmd(1'b0, 1'b1, '1, AW'(8), pat(402));
        model[8] = pat(402);
        step();
        chk("R9 late data after stall", dq_out, model[8]);

        // R11: sleep entry, ignored commands, exit
        desel('0);
        step();
        sleep = 1'b1;
        step();
        step();
        sel_cmd(1'b0, 1'b1, '1, AW'(3), '0);
        step();
        chk("R11 asleep read drive", WW'(dq_oe), '0);
        sel_cmd(1'b0, 1'b0, '0, AW'(3), pat(500));
        step();
        sel_cmd(1'b0, 1'b1, '1, AW'(3), pat(501));
        step();
        chk("R11 asleep drive", WW'(dq_oe), '0);
        sleep = 1'b0;
        desel(pat(502));
        step();
        step();
        sel_cmd(1'b0, 1'b1, '1, AW'(3), '0);
        step();
        chk("R11 contents kept", dq_out, model[3]);
        chk("R11 awake drive", WW'(dq_oe), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule